// File: doc/BRIEF.md
# Register Window Pointer Controller

This block tracks which window of a circular register-window file is current. It also holds the mask of windows that must not be entered. It serves five kinds of command. Save steps the pointer down by one and restore steps it up by one, both modulo the window count. Return-from-trap clears the way back out of a trap handler. Status write loads the packed status word. Mask write loads the invalid-window mask. A move whose destination window is marked in the mask is refused, and a trap is reported instead. A return-from-trap issued while traps are already enabled is illegal. A status write naming a window that does not exist is also illegal.

A command is given as one cycle of `req_valid` together with an opcode and a 32-bit data word. There is no back-pressure: every command presented is taken in that cycle, and one command is handled per cycle. All effects appear after the next rising edge. The packed status word and the mask are always visible on output pins. A trap is signalled by a one-cycle pulse on `trap_valid` together with a 2-bit cause. The register storage, trap vectoring and condition-code generation sit outside this block.

Top module: `win_ptr_ctrl`

## Requirements
- R1: Save (opcode 0) whose destination window is unmasked sets the pointer to pointer-1, and from 0 it wraps to NWIN-1.
- R2: Restore (opcode 1) whose destination window is unmasked sets the pointer to pointer+1, and from NWIN-1 it wraps to 0.
- R3: If the mask bit of the destination window is set, the pointer stays unchanged. Save then reports cause 1 (overflow) and restore reports cause 2 (underflow).
- R4: Return-from-trap (opcode 2) while the trap-enable bit is 1 reports cause 3 (illegal) and changes no state.
- R5: Return-from-trap while trap-enable is 0 sets trap-enable to 1 and targets pointer+1 with wrap. If that window is masked, it reports cause 2 and keeps the pointer. Otherwise it moves the pointer and copies the previous-supervisor bit into the supervisor bit.
- R6: Status write (opcode 3) with data bits [4:0] >= NWIN reports cause 3 and changes no state. Otherwise it loads the pointer from [4:0], trap-enable from bit 5, previous-supervisor from bit 6, supervisor from bit 7, interrupt level from [11:8], FPU-enable from bit 12 and condition codes from [23:20].
- R7: The status word carries the VERSION parameter at [31:24], condition codes at [23:20], zeros at [19:13], FPU-enable at 12, interrupt level at [11:8], supervisor at 7, previous-supervisor at 6, trap-enable at 5 and the pointer at [4:0].
- R8: Mask write (opcode 4) loads the mask from data bits [NWIN-1:0] without a trap. Bit i of the mask guards window i.
- R9: `trap_valid` is high only in the cycle after a command that traps. `trap_cause` is 0 whenever no trap is signalled.
- R10: After reset the pointer is 0, supervisor is 1, and trap-enable, previous-supervisor, interrupt level, FPU-enable, condition codes and the mask are all 0.
- R11: Opcodes 5 to 7 are ignored. They change no state and raise no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is presented this cycle |
| req_op | input | 3 | Command opcode |
| req_data | input | 32 | Status or mask write data |
| status_word | output | 32 | Packed status word |
| mask_word | output | NWIN | Invalid-window mask |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 2 | Trap cause: 1 overflow, 2 underflow, 3 illegal |

## Verification
Some rules hold on every cycle, and the assertions check them continuously. These are the pointer range, the modulo step of each unblocked move, the frozen pointer on a refused move, the illegal outcome of a repeated return-from-trap, the frozen state after a bad status write, and a trap only ever following a command. Other behaviour can only be shown by the bench's scenarios. That covers the exact bit layout of the status word, the supervisor-bit copy on return-from-trap, the mask load, and opcodes 5 to 7 having no effect. The bench runs a five-window configuration over every start window, mask setting and trap-enable state, and compares against an arithmetic model.

// File: rtl/win_ptr_pkg.sv
package win_ptr_pkg;
  typedef enum logic [2:0] {
    OP_SAVE    = 3'd0,
    OP_RESTORE = 3'd1,
    OP_RETT    = 3'd2,
    OP_WRSTAT  = 3'd3,
    OP_WRMASK  = 3'd4
  } win_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OVF  = 2'd1,
    CAUSE_UNF  = 2'd2,
    CAUSE_ILL  = 2'd3
  } trap_cause_e;

  typedef struct packed {
    logic [3:0] icc;
    logic       ef;
    logic [3:0] pil;
    logic       s;
    logic       ps;
    logic       et;
  } stat_flags_t;
endpackage

// File: rtl/win_step.sv
module win_step #(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input  logic [PW-1:0]   cur,
  input  logic [NWIN-1:0] mask,
  output logic [PW-1:0]   dec_ptr,
  output logic [PW-1:0]   inc_ptr,
  output logic            dec_blocked,
  output logic            inc_blocked
);
  localparam int SPAN = 1 << PW;
  localparam logic [PW-1:0] LAST = PW'(NWIN - 1);

  logic [SPAN-1:0] mpad;

  generate
    if (SPAN > NWIN) begin : g_pad
      assign mpad = {{(SPAN - NWIN){1'b0}}, mask};
    end else begin : g_full
      assign mpad = mask;
    end
  endgenerate

  assign dec_ptr     = (cur == '0)   ? LAST : cur - 1'b1;
  assign inc_ptr     = (cur == LAST) ? '0   : cur + 1'b1;
  assign dec_blocked = mpad[dec_ptr];
  assign inc_blocked = mpad[inc_ptr];
endmodule

// File: rtl/win_status_pack.sv
module win_status_pack
  import win_ptr_pkg::*;
#(
  parameter int          PW      = 3,
  parameter logic [7:0]  VERSION = 8'h31
) (
  input  stat_flags_t    flags,
  input  logic [PW-1:0]  cwp,
  output logic [31:0]    word
);
  assign word = {VERSION, flags.icc, 7'b0, flags.ef, flags.pil,
                 flags.s, flags.ps, flags.et, 5'(cwp)};
endmodule

// File: rtl/win_ptr_ctrl.sv
module win_ptr_ctrl
  import win_ptr_pkg::*;
#(
  parameter int         NWIN    = 8,
  parameter logic [7:0] VERSION = 8'h31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [31:0]     req_data,
  output logic [31:0]     status_word,
  output logic [NWIN-1:0] mask_word,
  output logic            trap_valid,
  output logic [1:0]      trap_cause
);
  localparam int PW = $clog2(NWIN);
  localparam logic [PW-1:0] LAST  = PW'(NWIN - 1);
  localparam logic [5:0]    NWIN6 = 6'(NWIN);

  logic [PW-1:0]   cwp_q;
  stat_flags_t     flags_q;
  logic [NWIN-1:0] mask_q;
  logic            trap_v_q;
  logic [1:0]      trap_c_q;

  logic [PW-1:0] dec_ptr, inc_ptr;
  logic          dec_blk, inc_blk;
  logic [4:0]    wr_cwp;
  logic          wr_ok;
  logic          unused_bits;

  assign wr_cwp      = req_data[4:0];
  assign wr_ok       = {1'b0, wr_cwp} < NWIN6;
  assign unused_bits = ^{req_data[31:24], req_data[19:13]};

  win_step #(.NWIN(NWIN), .PW(PW)) u_step (
    .cur(cwp_q), .mask(mask_q), .dec_ptr(dec_ptr), .inc_ptr(inc_ptr),
    .dec_blocked(dec_blk), .inc_blocked(inc_blk)
  );

  win_status_pack #(.PW(PW), .VERSION(VERSION)) u_pack (
    .flags(flags_q), .cwp(cwp_q), .word(status_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q    <= '0;
      flags_q  <= '{icc: 4'h0, ef: 1'b0, pil: 4'h0, s: 1'b1, ps: 1'b0, et: 1'b0};
      mask_q   <= '0;
      trap_v_q <= 1'b0;
      trap_c_q <= CAUSE_NONE;
    end else begin
      trap_v_q <= 1'b0;
      trap_c_q <= CAUSE_NONE;
      if (req_valid) begin
        case (req_op)
          OP_SAVE: begin
            if (dec_blk) begin
              trap_v_q <= 1'b1;
              trap_c_q <= CAUSE_OVF;
            end else begin
              cwp_q <= dec_ptr;
            end
          end
          OP_RESTORE: begin
            if (inc_blk) begin
              trap_v_q <= 1'b1;
              trap_c_q <= CAUSE_UNF;
            end else begin
              cwp_q <= inc_ptr;
            end
          end
          OP_RETT: begin
            if (flags_q.et) begin
              trap_v_q <= 1'b1;
              trap_c_q <= CAUSE_ILL;
            end else begin
              flags_q.et <= 1'b1;
              if (inc_blk) begin
                trap_v_q <= 1'b1;
                trap_c_q <= CAUSE_UNF;
              end else begin
                cwp_q     <= inc_ptr;
                flags_q.s <= flags_q.ps;
              end
            end
          end
          OP_WRSTAT: begin
            if (!wr_ok) begin
              trap_v_q <= 1'b1;
              trap_c_q <= CAUSE_ILL;
            end else begin
              cwp_q   <= wr_cwp[PW-1:0];
              flags_q <= '{icc: req_data[23:20], ef: req_data[12],
                           pil: req_data[11:8], s: req_data[7],
                           ps: req_data[6], et: req_data[5]};
            end
          end
          OP_WRMASK: mask_q <= req_data[NWIN-1:0];
          default: ;
        endcase
      end
    end
  end

  assign mask_word  = mask_q;
  assign trap_valid = trap_v_q;
  assign trap_cause = trap_c_q;

  p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_q <= LAST);

  p_save_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_SAVE && !dec_blk) |=>
      (cwp_q == (($past(cwp_q) == '0) ? LAST : $past(cwp_q) - 1'b1)));

  p_restore_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_RESTORE && !inc_blk) |=>
      (cwp_q == (($past(cwp_q) == LAST) ? '0 : $past(cwp_q) + 1'b1)));

  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_op == OP_SAVE && dec_blk) ||
                   (req_op == OP_RESTORE && inc_blk))) |=>
      ($stable(cwp_q) && trap_v_q));

  p_rett_twice_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_RETT && flags_q.et) |=>
      (trap_v_q && trap_c_q == CAUSE_ILL && $stable(cwp_q) && $stable(flags_q)));

  p_rett_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_RETT) |=> flags_q.et);

  p_bad_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_WRSTAT && !wr_ok) |=>
      ($stable(cwp_q) && $stable(flags_q) && trap_c_q == CAUSE_ILL));

  p_trap_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_v_q |-> $past(req_valid));

  p_quiet_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_v_q |-> (trap_c_q == CAUSE_NONE));
endmodule

// File: tb/win_ptr_ctrl_test.sv
module win_ptr_ctrl_test;
  localparam int NW = 5;
  localparam logic [7:0] VER = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [31:0] req_data = 32'd0;
  logic [31:0] status_word;
  logic [NW-1:0] mask_word;
  logic trap_valid;
  logic [1:0] trap_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_cwp = 0, m_pil = 0, m_icc = 0;
  bit m_et = 0, m_s = 1, m_ps = 0, m_ef = 0;
  bit [NW-1:0] m_mask = '0;

  always #5 clk = ~clk;

  win_ptr_ctrl #(.NWIN(NW), .VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .status_word(status_word), .mask_word(mask_word),
    .trap_valid(trap_valid), .trap_cause(trap_cause)
  );

  function automatic logic [31:0] exp_word();
    return {VER, 4'(m_icc), 7'b0, m_ef, 4'(m_pil), m_s, m_ps, m_et, 5'(m_cwp)};
  endfunction

  function automatic logic [31:0] mkstat(int cw, bit et, bit s, bit ps, int pil, bit ef, int icc);
    return {8'h00, 4'(icc), 7'b0, ef, 4'(pil), s, ps, et, 5'(cw)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [2:0] op, logic [31:0] data, string tag);
    int nxt;
    int ec = 0;
    case (op)
      3'd0: begin
        nxt = (m_cwp == 0) ? NW - 1 : m_cwp - 1;
        if (m_mask[nxt]) ec = 1; else m_cwp = nxt;
      end
      3'd1: begin
        nxt = (m_cwp == NW - 1) ? 0 : m_cwp + 1;
        if (m_mask[nxt]) ec = 2; else m_cwp = nxt;
      end
      3'd2: begin
        if (m_et) ec = 3;
        else begin
          m_et = 1;
          nxt = (m_cwp == NW - 1) ? 0 : m_cwp + 1;
          if (m_mask[nxt]) ec = 2;
          else begin m_cwp = nxt; m_s = m_ps; end
        end
      end
      3'd3: begin
        if (int'(data[4:0]) >= NW) ec = 3;
        else begin
          m_cwp = int'(data[4:0]); m_et = data[5]; m_ps = data[6]; m_s = data[7];
          m_pil = int'(data[11:8]); m_ef = data[12]; m_icc = int'(data[23:20]);
        end
      end
      3'd4: m_mask = data[NW-1:0];
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " trap_valid R9"}, 32'(trap_valid), 32'(ec != 0));
    check({tag, " trap_cause"}, 32'(trap_cause), 32'(ec));
    check({tag, " status_word R7"}, status_word, exp_word());
    check({tag, " mask_word R8"}, 32'(mask_word), 32'(m_mask));
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("idle pulse ended R9", 32'(trap_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("reset status R10", status_word, exp_word());
    check("reset mask R10", 32'(mask_word), 32'd0);
    check("reset trap R10", 32'(trap_valid), 32'd0);

    // R7: a distinctive field pattern lands at the documented positions
    send(3'd3, mkstat(3, 0, 0, 1, 12, 1, 9), "layout R7 R6");
    check("layout literal R7", status_word, 32'hA5_90_1C_43);

    // R6: sweep every pointer field value, legal and illegal
    for (int v = 0; v < 32; v++) begin
      send(3'd3, mkstat(v, v[0], v[1], v[2], v % 16, v[3], 15 - (v % 16)), "wrstat sweep R6");
    end

    // R1 R2 R3: every start window, destination masked or not
    for (int st = 0; st < NW; st++) begin
      for (int blk = 0; blk < 2; blk++) begin
        int dn = (st == 0) ? NW - 1 : st - 1;
        int up = (st == NW - 1) ? 0 : st + 1;
        send(3'd4, blk ? (32'd1 << dn) : 32'd0, "mask load R8");
        send(3'd3, mkstat(st, 0, 1, 0, 0, 0, 0), "setup R6");
        send(3'd0, 32'd0, "save R1 R3");
        idle_check();
        send(3'd4, blk ? (32'd1 << up) : (32'd1 << dn), "mask load R8");
        send(3'd3, mkstat(st, 0, 1, 0, 0, 0, 0), "setup R6");
        send(3'd1, 32'd0, "restore R2 R3");
      end
    end

    // R4 R5: return-from-trap over start window, prev-supervisor, mask, enable
    for (int st = 0; st < NW; st++) begin
      for (int k = 0; k < 8; k++) begin
        int up = (st == NW - 1) ? 0 : st + 1;
        send(3'd4, k[1] ? (32'd1 << up) : 32'd0, "mask load R8");
        send(3'd3, mkstat(st, k[2], ~k[0], k[0], 5, 0, 3), "setup R6");
        send(3'd2, 32'd0, k[2] ? "rett enabled R4" : "rett R5");
      end
    end
    // R4: a second return-from-trap right after a good one is illegal
    send(3'd4, 32'd0, "mask clear R8");
    send(3'd3, mkstat(2, 0, 0, 1, 0, 0, 0), "setup R6");
    send(3'd2, 32'd0, "rett first R5");
    send(3'd2, 32'd0, "rett repeat R4");

    // R11: unused opcodes touch nothing
    send(3'd4, 32'h0000_0015, "mask load R8");
    for (int op = 5; op < 8; op++) begin
      send(3'(op), 32'hFFFF_FFFF, "unused opcode R11");
    end
    idle_check();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule